// File: doc/BRIEF.md
# Bus Address and Attribute Breakpoint Comparator

This block snoops every transfer presented on a processor local bus and raises a one-cycle trigger when that transfer meets a programmed breakpoint condition. The condition has two halves that must both hold: an address test and an attribute test. The address test compares the transfer address against a lower and an upper bound register. A two-bit mode input chooses exact equality with the lower bound, membership in the inclusive span between the bounds, or lying outside that span. The mode can also turn triggering off.

The attribute test covers four transfer attributes: the read/write direction, the access size, the transfer type and the transfer modifier. One 16-bit attribute register holds a value for each attribute in its lower byte and a per-bit mask in its upper byte. A masked bit drops out of the comparison. Reserved codes get no special handling and are compared bit for bit. A simple register-write port loads the three registers. The trigger is registered, so it appears on the clock edge after the sampling edge.

Top module: `bkpt_match`

## Requirements
- R1: Synchronous active-low reset clears the lower bound, upper bound and attribute register to zero and drives `trig_o` low. After reset, an exact-mode transfer to address 0 that is a write (rw=0) with size 00, type 00 and modifier 000 triggers.
- R2: When `wr_en_i` is high, `wr_sel_i`=0 loads the lower bound from `wr_data_i`, 1 loads the upper bound, and 2 loads the attribute register from `wr_data_i[15:0]`. A write with `wr_sel_i`=3 changes no register.
- R3: With `mode_i`=00, no transfer ever triggers.
- R4: With `mode_i`=01, the address condition holds only when the bus address equals the lower bound.
- R5: With `mode_i`=10, the address condition holds when lower bound <= address <= upper bound, with both bounds included.
- R6: With `mode_i`=11, the address condition holds when the address is below the lower bound or above the upper bound.
- R7: The attribute register layout is as follows. Bit 7 holds the expected `bus_rw_i` (1 = read). Bits 6:5 hold the expected size (00 long, 01 byte, 10 word). Bits 4:3 hold the expected type (00 normal, 10 emulator, 11 acknowledge/CPU space). Bits 2:0 hold the expected modifier. An unmasked bit that differs from the bus blocks the trigger.
- R8: Bits 15, 14:13, 12:11 and 10:8 mask the read/write, size, type and modifier value bits one for one. A set mask bit makes the matching bit always count as equal.
- R9: Reserved codes (size 11, type 01, unused modifier codes) are compared bit by bit like any other value.
- R10: `trig_o` goes high on the clock edge after the edge that samples a transfer with `bus_valid_i` high and both conditions true. It stays high for exactly one cycle per such transfer and never rises for a transfer with `bus_valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 lower, 1 upper, 2 attribute, 3 none |
| wr_data_i | input | ADDR_W | Write data |
| mode_i | input | 2 | Address condition: 00 off, 01 exact, 10 inside, 11 outside |
| bus_valid_i | input | 1 | Transfer valid strobe |
| bus_addr_i | input | ADDR_W | Transfer address |
| bus_rw_i | input | 1 | Direction, 1 = read |
| bus_size_i | input | 2 | Transfer size |
| bus_tt_i | input | 2 | Transfer type |
| bus_tm_i | input | 3 | Transfer modifier |
| trig_o | output | 1 | Registered one-cycle breakpoint trigger |

## Verification
The bench builds the block with the default `ADDR_W` of 32. This puts bounds such as 0x1000 and 0x1FFF, and the addresses just past each bound, within reach, so the inclusive edges and both sides of the outside span are each exercised. The attribute side is always 16 bits wide whatever the address width. Every masked, unmasked and reserved code therefore comes up at this one width.

// File: rtl/bkpt_pkg.sv
// Package: shared constants and types for the breakpoint comparator.
// Assumes the attribute register is always 16 bits: a mask byte over a value byte.
package bkpt_pkg;
    localparam int ATTR_W = 16;
    localparam int VAL_W  = ATTR_W / 2;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_EXACT   = 2'b01,
        MODE_INSIDE  = 2'b10,
        MODE_OUTSIDE = 2'b11
    } bkpt_mode_e;

    typedef enum logic [1:0] {
        SEL_LOW  = 2'b00,
        SEL_HIGH = 2'b01,
        SEL_ATTR = 2'b10,
        SEL_NONE = 2'b11
    } bkpt_sel_e;
endpackage

// File: rtl/bkpt_regs.sv
// Module: holds the lower bound, upper bound and attribute registers.
// Assumes ADDR_W >= ATTR_W; the attribute register takes the low 16 data bits.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [ADDR_W-1:0]   wr_data_i,
    output logic [ADDR_W-1:0]   lo_o,
    output logic [ADDR_W-1:0]   hi_o,
    output logic [ATTR_W-1:0]   attr_o
);
    bkpt_sel_e sel;
    assign sel = bkpt_sel_e'(wr_sel_i);

    // Purpose: load the selected register, or clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_o   <= '0;
            hi_o   <= '0;
            attr_o <= '0;
        end else if (wr_en_i) begin
            case (sel)
                SEL_LOW:  lo_o   <= wr_data_i;
                SEL_HIGH: hi_o   <= wr_data_i;
                SEL_ATTR: attr_o <= wr_data_i[ATTR_W-1:0];
                default:  ;
            endcase
        end
    end

    AST_LOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en_i) && $past(wr_sel_i) == 2'b00 |-> lo_o == $past(wr_data_i)); // R2
    AST_NONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en_i) && $past(wr_sel_i) == 2'b11 |-> $stable(lo_o) && $stable(hi_o) && $stable(attr_o)); // R2
endmodule

// File: rtl/bkpt_addr_cmp.sv
// Module: evaluates the selected address condition against the bounds.
// Assumes unsigned addresses; OFF mode yields no hit.
module bkpt_addr_cmp
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]          mode_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [ADDR_W-1:0]   lo_i,
    input  logic [ADDR_W-1:0]   hi_i,
    output logic                hit_o
);
    logic eq_lo, ge_lo, le_hi, in_span;
    bkpt_mode_e mode;
    assign mode = bkpt_mode_e'(mode_i);

    // Purpose: raw magnitude comparisons against both bounds.
    always_comb begin
        eq_lo   = (addr_i == lo_i);
        ge_lo   = (addr_i >= lo_i);
        le_hi   = (addr_i <= hi_i);
        in_span = ge_lo && le_hi;
    end

    // Purpose: pick the condition requested by the mode.
    always_comb begin
        case (mode)
            MODE_EXACT:   hit_o = eq_lo;
            MODE_INSIDE:  hit_o = in_span;
            MODE_OUTSIDE: hit_o = !in_span;
            default:      hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bkpt_attr_cmp.sv
// Module: masked bitwise compare of bus attributes with the attribute register.
// Assumes value byte order {rw, size[1:0], tt[1:0], tm[2:0]} with masks in the upper byte.
module bkpt_attr_cmp
    import bkpt_pkg::*;
(
    input  logic [ATTR_W-1:0]   attr_i,
    input  logic                rw_i,
    input  logic [1:0]          size_i,
    input  logic [1:0]          tt_i,
    input  logic [2:0]          tm_i,
    output logic                hit_o
);
    logic [VAL_W-1:0] bus_vec;
    logic [VAL_W-1:0] bit_ok;

    // Purpose: pack bus attributes into the register's value-byte order.
    always_comb bus_vec = {rw_i, size_i, tt_i, tm_i};

    genvar gi;
    generate
        for (gi = 0; gi < VAL_W; gi++) begin : g_bit
            // Purpose: one bit passes if masked or equal.
            always_comb bit_ok[gi] = attr_i[VAL_W + gi] || (bus_vec[gi] == attr_i[gi]);
        end
    endgenerate

    // Purpose: all bits must pass.
    always_comb hit_o = &bit_ok;
endmodule

// File: rtl/bkpt_match.sv
// Module: top of the breakpoint comparator; registers a one-cycle trigger.
// Assumes a transfer lasts one cycle with bus_valid_i high; reset is synchronous active-low.
module bkpt_match
    import bkpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_sel_i,
    input  logic [ADDR_W-1:0]   wr_data_i,
    input  logic [1:0]          mode_i,
    input  logic                bus_valid_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic                bus_rw_i,
    input  logic [1:0]          bus_size_i,
    input  logic [1:0]          bus_tt_i,
    input  logic [2:0]          bus_tm_i,
    output logic                trig_o
);
    logic [ADDR_W-1:0] lo, hi;
    logic [ATTR_W-1:0] attr;
    logic addr_hit, attr_hit;

    bkpt_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .lo_o(lo), .hi_o(hi), .attr_o(attr)
    );

    bkpt_addr_cmp #(.ADDR_W(ADDR_W)) u_addr (
        .mode_i(mode_i), .addr_i(bus_addr_i), .lo_i(lo), .hi_i(hi), .hit_o(addr_hit)
    );

    bkpt_attr_cmp u_attr (
        .attr_i(attr), .rw_i(bus_rw_i), .size_i(bus_size_i), .tt_i(bus_tt_i),
        .tm_i(bus_tm_i), .hit_o(attr_hit)
    );

    // Purpose: register the trigger pulse for a valid matching transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_o <= 1'b0;
        else        trig_o <= bus_valid_i && addr_hit && attr_hit;
    end

    AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(bus_valid_i)); // R10
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(mode_i) != 2'b00); // R3
    AST_EXACT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o && $past(mode_i) == 2'b01 |-> $past(bus_addr_i) == $past(lo)); // R4
    AST_INSIDE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o && $past(mode_i) == 2'b10 |-> $past(bus_addr_i) >= $past(lo) && $past(bus_addr_i) <= $past(hi)); // R5
    AST_OUTSIDE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o && $past(mode_i) == 2'b11 |-> $past(bus_addr_i) < $past(lo) || $past(bus_addr_i) > $past(hi)); // R6
    AST_ATTR_UNMASKED_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ((({$past(bus_rw_i), $past(bus_size_i), $past(bus_tt_i), $past(bus_tm_i)}
                     ^ $past(attr[VAL_W-1:0])) & ~$past(attr[ATTR_W-1:VAL_W])) == '0)); // R7
endmodule

// File: tb/bkpt_match_test.sv
`timescale 1ns/1ps
module bkpt_match_test;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic [1:0] mode = '0;
    logic valid = 1'b0;
    logic [AW-1:0] addr = '0;
    logic rw = 1'b0;
    logic [1:0] size = '0;
    logic [1:0] tt = '0;
    logic [2:0] tm = '0;
    logic trig;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    bkpt_match #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .mode_i(mode), .bus_valid_i(valid), .bus_addr_i(addr), .bus_rw_i(rw),
        .bus_size_i(size), .bus_tt_i(tt), .bus_tm_i(tm), .trig_o(trig)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [31:0] a;
        logic        r;
        logic [1:0]  sz;
        logic [1:0]  t;
        logic [2:0]  m;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    // Bounds 0x1000..0x1FFF; attr 0x6780 = size and modifier masked, read, type normal.
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 32'h1000, 1'b1, 2'd2, 2'd0, 3'd5, 1'b1, 4'd4},
        '{2'b01, 32'h1001, 1'b1, 2'd2, 2'd0, 3'd5, 1'b0, 4'd4},
        '{2'b10, 32'h1000, 1'b1, 2'd0, 2'd0, 3'd1, 1'b1, 4'd5},
        '{2'b10, 32'h1FFF, 1'b1, 2'd0, 2'd0, 3'd1, 1'b1, 4'd5},
        '{2'b10, 32'h0FFF, 1'b1, 2'd0, 2'd0, 3'd1, 1'b0, 4'd5},
        '{2'b10, 32'h2000, 1'b1, 2'd0, 2'd0, 3'd1, 1'b0, 4'd5},
        '{2'b11, 32'h0FFF, 1'b1, 2'd1, 2'd0, 3'd2, 1'b1, 4'd6},
        '{2'b11, 32'h2000, 1'b1, 2'd1, 2'd0, 3'd2, 1'b1, 4'd6},
        '{2'b11, 32'h1800, 1'b1, 2'd1, 2'd0, 3'd2, 1'b0, 4'd6},
        '{2'b00, 32'h1000, 1'b1, 2'd2, 2'd0, 3'd5, 1'b0, 4'd3},
        '{2'b10, 32'h1500, 1'b0, 2'd0, 2'd0, 3'd1, 1'b0, 4'd7},
        '{2'b10, 32'h1500, 1'b1, 2'd0, 2'd2, 3'd5, 1'b0, 4'd7},
        '{2'b10, 32'h1500, 1'b1, 2'd3, 2'd0, 3'd7, 1'b1, 4'd8}
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: trig actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive one transfer before an edge; check the trigger after that edge.
    task automatic xfer(input logic [1:0] md, input logic [AW-1:0] a, input logic r,
                        input logic [1:0] sz, input logic [1:0] t, input logic [2:0] m,
                        input logic v, input logic exp, input string req);
        @(negedge clk);
        mode = md; addr = a; rw = r; size = sz; tt = t; tm = m; valid = v;
        @(negedge clk);
        check(req, trig, exp);
        valid = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", trig, 1'b0);
        rst_n = 1'b1;
        xfer(2'b01, 32'h0, 1'b0, 2'd0, 2'd0, 3'd0, 1'b1, 1'b1, "R1");
        xfer(2'b01, 32'h4, 1'b0, 2'd0, 2'd0, 3'd0, 1'b1, 1'b0, "R1");

        // R2: load registers
        wr(2'b00, 32'h1000);
        wr(2'b01, 32'h1FFF);
        wr(2'b10, 32'hFFFF_6780);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            xfer(VECS[i].md, VECS[i].a, VECS[i].r, VECS[i].sz, VECS[i].t, VECS[i].m,
                 1'b1, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
        end

        // R2: select 3 writes nothing
        wr(2'b11, 32'hFFFF_FFFF);
        xfer(2'b01, 32'h1000, 1'b1, 2'd2, 2'd0, 3'd5, 1'b1, 1'b1, "R2");
        xfer(2'b10, 32'h1FFF, 1'b1, 2'd2, 2'd0, 3'd5, 1'b1, 1'b1, "R2");

        // R10: no trigger without valid
        xfer(2'b01, 32'h1000, 1'b1, 2'd2, 2'd0, 3'd5, 1'b0, 1'b0, "R10");
        // R10: single transfer gives a single-cycle pulse
        xfer(2'b01, 32'h1000, 1'b1, 2'd2, 2'd0, 3'd5, 1'b1, 1'b1, "R10");
        @(negedge clk);
        check("R10", trig, 1'b0);

        // R9: reserved codes compared bit by bit (attr 0x00EB: read, size 11, type 01, mod 011)
        wr(2'b10, 32'h0000_00EB);
        xfer(2'b10, 32'h1500, 1'b1, 2'd3, 2'd1, 3'd3, 1'b1, 1'b1, "R9");
        xfer(2'b10, 32'h1500, 1'b1, 2'd3, 2'd2, 3'd3, 1'b1, 1'b0, "R9");
        xfer(2'b10, 32'h1500, 1'b1, 2'd3, 2'd1, 3'd2, 1'b1, 1'b0, "R9");
        // R8: read/write mask alone lets a write through
        wr(2'b10, 32'h0000_80EB);
        xfer(2'b10, 32'h1500, 1'b0, 2'd3, 2'd1, 3'd3, 1'b1, 1'b1, "R8");

        // R1: reset mid-run clears bounds and attributes
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", trig, 1'b0);
        rst_n = 1'b1;
        xfer(2'b01, 32'h1000, 1'b0, 2'd0, 2'd0, 3'd0, 1'b1, 1'b0, "R1");
        xfer(2'b01, 32'h0, 1'b0, 2'd0, 2'd0, 3'd0, 1'b1, 1'b1, "R1");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule